// File: doc/BRIEF.md
# Keepalive Watchdog Timer

This block is a software-supervised watchdog on a simple byte-wide I/O register bus with an address, a write strobe, a read strobe and write data. It has two registers: a control/status register and a keepalive register. Software sets the enable bit, picks one of four timeout periods and chooses what an expiry does. It must then write the keepalive register often enough to stop the count from running out. The value written there does not matter.

The timeout period comes from a free-running prescaler followed by a tick counter. When the count runs out, the block either sends a one-cycle system-reset request or raises a system-error interrupt level. It also sets a sticky timeout flag. Software clears this flag by writing a 1 to it, and that same write drops the interrupt level. A reset of the block always leaves the watchdog disabled.

Top module: `wdog_keepalive`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), the watchdog is disabled, rst_req and serr_irq are 0, and the control/status register reads 0x00.
- R2: The registers sit in an I/O window based at BASE_ADDR (default 0x600). The keepalive register is at 0x60D and the control/status register is at 0x60E. Control/status bit layout: bit 0 is enable, bits 2:1 are the period select, bit 3 is the action (0 = reset request, 1 = system-error interrupt), bit 7 is the timeout flag, and bits 6:4 read 0. A read returns its data on bus_rdata one cycle after the read strobe. Reads of the keepalive address, reads of any other address, and idle cycles all return 0x00.
- R3: With enable set, expiry happens at exactly PRESCALE*BASE_TICKS*4^sel clock edges after the last restart. With the defaults this is 16, 64, 256 or 1024 cycles. The outputs change at that edge.
- R4: Any write to the keepalive address restarts the count, whatever the data. Writes to other addresses in the window do not restart the count.
- R5: Any write to the control/status register also restarts the count, so a stale count cannot expire right after reconfiguration.
- R6: While enable is 0, no expiry occurs, and a keepalive write has no effect on the outputs.
- R7: With action 0, an expiry gives a single-cycle pulse on rst_req.
- R8: With action 1, an expiry raises serr_irq. serr_irq stays high until the flag is cleared.
- R9: The timeout flag is sticky. It is cleared only by a control/status write with bit 7 set. A write with bit 7 clear leaves the flag as it was.
- R10: Same-cycle cases. A keepalive write or control/status write on the expiring edge wins, so no expiry occurs on that edge. A read on the expiring edge returns the flag value from before the expiry.
- R11: After an expiry the count starts again from zero, so the next expiry comes one full period later if no refresh is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rst_req | output | 1 | One-cycle system-reset request |
| serr_irq | output | 1 | System-error interrupt level |

## Verification
Expiry can fall in the same cycle as a keepalive write, a control/status write or a read. The bench provokes each case by idling exactly one cycle less than the selected period after a restart, then issuing the access. The per-cycle reference model decides the winner: no pulse for a refresh or reconfiguration, and the pre-expiry flag value returned for a read. Explicit checks then confirm that the next expiry comes a full period after the refresh.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // register offsets inside the I/O window
  localparam int OFF_KICK = 'h0D;
  localparam int OFF_CSR  = 'h0E;
  // control/status field positions
  localparam int EN_BIT   = 0;
  localparam int SEL_LSB  = 1;
  localparam int ACT_BIT  = 3;
  localparam int FLAG_BIT = 7;
  localparam int SEL_W    = 2;

  typedef enum logic {ACT_RESET = 1'b0, ACT_SERR = 1'b1} wd_action_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0] div_q;

  assign tick = run && (div_q == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || !run || tick) div_q <= '0;
    else                            div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int BASE_TICKS = 4,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int NSEL   = 1 << SEL_W;
  localparam int MAX_L  = BASE_TICKS << (2 * (NSEL - 1));
  localparam int TICK_W = $clog2(MAX_L + 1);

  logic [TICK_W-1:0] last_tick [NSEL];
  logic [TICK_W-1:0] ticks_q;

  // each select is four times longer than the one below
  for (genvar s = 0; s < NSEL; s++) begin : g_lim
    assign last_tick[s] = TICK_W'((BASE_TICKS << (2 * s)) - 1);
  end

  assign expire = run && tick && !clr && (ticks_q == last_tick[sel]);

  always_ff @(posedge clk) begin
    if (rst || clr || !run || expire) ticks_q <= '0;
    else if (tick)                    ticks_q <= ticks_q + 1'b1;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire,
  output logic              en_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              restart,
  output logic              flag_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              serr_irq
);
  localparam logic [ADDR_W-1:0] KICK_ADDR = ADDR_W'(BASE_ADDR + ADDR_W'(OFF_KICK));
  localparam logic [ADDR_W-1:0] CSR_ADDR  = ADDR_W'(BASE_ADDR + ADDR_W'(OFF_CSR));

  wd_action_e        act_q;
  logic              kick_hit, csr_hit, flag_clr;
  logic [DATA_W-1:0] csr_view;

  assign kick_hit = bus_wr && (bus_addr == KICK_ADDR);
  assign csr_hit  = bus_wr && (bus_addr == CSR_ADDR);
  assign flag_clr = csr_hit && bus_wdata[FLAG_BIT];
  assign restart  = kick_hit || csr_hit;

  always_comb begin
    csr_view                          = '0;
    csr_view[EN_BIT]                  = en_q;
    csr_view[SEL_LSB +: SEL_W]        = sel_q;
    csr_view[ACT_BIT]                 = act_q;
    csr_view[FLAG_BIT]                = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      act_q <= ACT_RESET;
    end else if (csr_hit) begin
      en_q  <= bus_wdata[EN_BIT];
      sel_q <= bus_wdata[SEL_LSB +: SEL_W];
      act_q <= wd_action_e'(bus_wdata[ACT_BIT]);
    end
  end

  // expiry and a control write never share an edge: a write restarts the count
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      serr_irq <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      rst_req <= expire && (act_q == ACT_RESET);
      if (expire)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (expire && (act_q == ACT_SERR)) serr_irq <= 1'b1;
      else if (flag_clr)                 serr_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  bus_rdata <= '0;
    else if (bus_rd && (bus_addr == CSR_ADDR)) bus_rdata <= csr_view;
    else                                      bus_rdata <= '0;
  end
endmodule

// File: rtl/wdog_keepalive.sv
module wdog_keepalive
  import wdog_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h0600,
  parameter int                PRESCALE   = 4,
  parameter int                BASE_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              serr_irq
);
  logic             en_q, flag_q, restart, tick, expire;
  logic [SEL_W-1:0] sel_q;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
  ) i_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expire(expire),
    .en_q(en_q), .sel_q(sel_q), .restart(restart), .flag_q(flag_q),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .serr_irq(serr_irq)
  );

  wdog_prescale #(.PRESCALE(PRESCALE)) i_pre (
    .clk(clk), .rst(rst), .run(en_q), .clr(restart), .tick(tick)
  );

  wdog_count #(.BASE_TICKS(BASE_TICKS), .SEL_W(SEL_W)) i_cnt (
    .clk(clk), .rst(rst), .run(en_q), .clr(restart), .tick(tick),
    .sel(sel_q), .expire(expire)
  );
endmodule

// File: rtl/wdog_keepalive_chk.sv
module wdog_keepalive_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0600
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              en_q,
  input logic              flag_q,
  input logic              rst_req,
  input logic              serr_irq
);
  localparam logic [ADDR_W-1:0] KICK_A = ADDR_W'(BASE_ADDR + ADDR_W'(wdog_pkg::OFF_KICK));
  localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(BASE_ADDR + ADDR_W'(wdog_pkg::OFF_CSR));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!rst_req && !serr_irq && !flag_q && !en_q && bus_rdata == '0));

  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> flag_q);

  a_r8_serr_needs_flag: assert property (@(posedge clk) disable iff (rst)
    serr_irq |-> flag_q);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(bus_wr && bus_addr == CSR_A && bus_wdata[wdog_pkg::FLAG_BIT])) |=> flag_q);

  a_r10_kick_beats_expiry: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == KICK_A) |=> (!rst_req && !$rose(serr_irq)));

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (!rst_req && !$rose(serr_irq)));
endmodule

bind wdog_keepalive wdog_keepalive_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) i_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_q(en_q),
  .flag_q(flag_q), .rst_req(rst_req), .serr_irq(serr_irq)
);

// File: tb/test_wdog_keepalive.sv
module test_wdog_keepalive;
  localparam int P = 4;
  localparam int B = 4;
  localparam logic [15:0] KICK = 16'h060D;
  localparam logic [15:0] CSR  = 16'h060E;

  logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  wire  [7:0]  bus_rdata;
  wire         rst_req, serr_irq;

  wdog_keepalive i_wdog_keepalive (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .serr_irq(serr_irq)
  );

  always #10 clk = ~clk;

  int    total = 0, bad = 0;
  string phase = "R1";
  bit    live = 0;

  function automatic int period(input int s);
    return P * B * (1 << (2 * s));
  endfunction

  // behavioural reference: one cycle counter since last restart
  bit         m_en = 0, m_act = 0, m_flag = 0, m_rst = 0, m_serr = 0;
  logic [1:0] m_sel = 0;
  int         m_cnt = 0;
  logic [7:0] m_rdata = 0;

  always @(posedge clk) begin
    logic [7:0] view;
    bit kick, cw, expire;
    view = 8'h00;
    view[0] = m_en; view[2:1] = m_sel; view[3] = m_act; view[7] = m_flag;
    if (rst) begin
      m_en = 0; m_act = 0; m_flag = 0; m_rst = 0; m_serr = 0;
      m_sel = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      m_rdata = (bus_rd && bus_addr == CSR) ? view : 8'h00;
      kick    = bus_wr && bus_addr == KICK;
      cw      = bus_wr && bus_addr == CSR;
      expire  = m_en && !kick && !cw && (m_cnt == period(int'(m_sel)) - 1);
      m_rst   = expire && !m_act;
      if (expire && m_act)          m_serr = 1;
      else if (cw && bus_wdata[7])  m_serr = 0;
      if (expire)                   m_flag = 1;
      else if (cw && bus_wdata[7])  m_flag = 0;
      if (kick || cw || !m_en || expire) m_cnt = 0;
      else                               m_cnt = m_cnt + 1;
      if (cw) begin
        m_en = bus_wdata[0]; m_sel = bus_wdata[2:1]; m_act = bus_wdata[3];
      end
    end
    live = 1;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check(phase, "cycle rdata", 32'(bus_rdata), 32'(m_rdata));
      check(phase, "cycle rst_req", 32'(rst_req), 32'(m_rst));
      check(phase, "cycle serr_irq", 32'(serr_irq), 32'(m_serr));
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic time_to(input bit use_serr, input int lim, output int n);
    n = 0;
    while (n < lim && !(use_serr ? serr_irq : rst_req)) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    idle(3);
    check("R1", "rst_req in reset", 32'(rst_req), 0);
    check("R1", "serr_irq in reset", 32'(serr_irq), 0);
    rst = 0;
    rd(CSR, v);
    check("R1", "csr after reset", 32'(v), 0);

    phase = "R3";
    for (int s = 0; s < 4; s++) begin
      wr(CSR, {4'b0000, 1'b0, 2'(s), 1'b1});
      time_to(0, 2000, n);
      check("R3", "expiry period", 32'(n), 32'(period(s)));
      if (s == 0) begin
        phase = "R7";
        idle(1);
        check("R7", "pulse one cycle", 32'(rst_req), 0);
        phase = "R11";
        time_to(0, 2000, n);
        check("R11", "second expiry", 32'(n), 32'(period(0) - 1));
        phase = "R3";
      end
    end

    phase = "R2";
    rd(KICK, v);
    check("R2", "keepalive reads zero", 32'(v), 0);
    rd(16'h0601, v);
    check("R2", "other address reads zero", 32'(v), 0);

    phase = "R4";
    wr(CSR, 8'h01);
    for (int k = 0; k < 6; k++) begin
      idle(12);
      check("R4", "no pulse while refreshed", 32'(rst_req), 0);
      wr(KICK, 8'(k * 8'h37));
    end
    idle(5);
    wr(16'h060C, 8'hFF);
    time_to(0, 2000, n);
    check("R4", "foreign write no restart", 32'(n), 10);

    phase = "R5";
    wr(CSR, 8'h01);
    idle(10);
    wr(CSR, 8'h01);
    time_to(0, 2000, n);
    check("R5", "csr write restarts", 32'(n), 16);

    phase = "R8";
    wr(CSR, 8'h89);
    time_to(1, 2000, n);
    check("R8", "serr expiry", 32'(n), 16);
    rd(CSR, v);
    check("R2", "csr layout with flag", 32'(v), 32'h89);
    idle(20);
    check("R8", "serr held", 32'(serr_irq), 1);
    phase = "R9";
    wr(CSR, 8'h09);
    rd(CSR, v);
    check("R9", "flag kept on bit7=0", 32'(v), 32'h89);
    wr(CSR, 8'h88);
    check("R8", "serr cleared", 32'(serr_irq), 0);
    rd(CSR, v);
    check("R9", "flag cleared", 32'(v), 32'h08);

    phase = "R6";
    time_to(1, 100, n);
    check("R6", "no expiry when disabled", 32'(n), 100);
    wr(KICK, 8'h5A);
    idle(40);
    check("R6", "kick while disabled", 32'(serr_irq) | 32'(rst_req), 0);

    phase = "R10";
    wr(CSR, 8'h01);
    idle(15);
    wr(KICK, 8'h00);
    check("R10", "kick on expiry edge", 32'(rst_req), 0);
    time_to(0, 2000, n);
    check("R10", "period after late kick", 32'(n), 16);
    idle(1);
    idle(14);
    wr(CSR, 8'h01);
    check("R10", "csr write on expiry edge", 32'(rst_req), 0);
    wr(CSR, 8'h89);
    idle(15);
    rd(CSR, v);
    check("R10", "read on expiry edge", 32'(v), 32'h09);
    rd(CSR, v);
    check("R10", "read after expiry", 32'(v), 32'h89);
    wr(CSR, 8'h80);
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule